// File: doc/BRIEF.md
# Direct-Mapped Data Cache with Victim Buffer

This block is a small data cache that sits between a CPU-side load/store port and a next-level memory. Lines are placed first in a direct-mapped primary array. When a line is pushed out of its primary slot, it is kept in a tiny fully associative victim buffer. Two lines that share a set index can therefore both stay on chip without a trip to memory.

A request always checks the primary array first. On a primary miss the victim buffer is searched, and only when both miss is a whole line requested from the next level. A buffer hit exchanges the buffer line with the current primary occupant. A refill pushes the current primary occupant into the buffer. When the buffer is full, the least recently used buffer line is dropped.

Stores are written through to the next level on a dedicated write port and never allocate on a miss. Cached lines are therefore always clean and can be dropped at any time.

Top module: `dmvc_cache`

## Requirements
- R1: After reset, `req_ready` is 1 and `rsp_valid`, `fill_req` and `wt_valid` are 0. No line is valid, so the first read of any address requests a refill.
- R2: A request that hits the primary array is accepted and answered with `rsp_valid` in the next cycle, with no refill. A read returns the addressed word, where word k of a line is `fill_data[k*WORD_W +: WORD_W]` and k is the low `log2(WPL)` address bits.
- R3: The victim buffer is searched only after a primary miss. A buffer hit raises `rsp_valid` two cycles after acceptance, returns the correct word, and makes no refill request.
- R4: On a buffer hit, the hit line moves into the primary slot and the displaced primary line takes the freed buffer entry. A repeat access to the hit line then hits the primary array, and an access to the displaced line hits the buffer.
- R5: A read that misses both structures raises `fill_req` with `fill_addr` equal to the line address (`req_addr >> log2(WPL)`). `fill_req` and `fill_addr` hold until `fill_valid`, and `rsp_valid` follows one cycle after `fill_valid` with the addressed word of `fill_data`.
- R6: On a refill, the line displaced from the primary slot, if valid, is placed in the victim buffer, in the lowest-numbered free entry when one exists.
- R7: When the buffer is full and must take a line, its least recently used line is dropped. A later access to the dropped line requests a refill.
- R8: Buffer recency is updated on every buffer hit and every insertion into the buffer.
- R9: Every accepted store raises `wt_valid` for one cycle, in the cycle after acceptance, carrying the store's address and data. A store that hits either structure updates the cached word. A store that misses both is answered in one cycle and does not allocate.
- R10: `req_ready` is 0 while a swap or a refill is in progress.
- R11: Buffer entries match on the full line address, so lines with the same set index but different tags can share the buffer, and no line matches more than one entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | CPU request present |
| req_ready | output | 1 | Cache can accept a request |
| req_we | input | 1 | 1 for a store, 0 for a load |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | WORD_W | Store data |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | WORD_W | Load data |
| fill_req | output | 1 | Line refill request, held until served |
| fill_addr | output | ADDR_W-log2(WPL) | Line address to refill |
| fill_valid | input | 1 | Refill line present on fill_data |
| fill_data | input | WORD_W*WPL | Refill line |
| wt_valid | output | 1 | Write-through pulse |
| wt_addr | output | ADDR_W | Write-through word address |
| wt_data | output | WORD_W | Write-through data |

## Verification
The assertions are checked on every cycle. They cover the following:
- the handshake rules: the busy state blocks acceptance, and the refill request is held stable until served;
- that each write-through pulse matches an accepted store;
- that every response has a cause;
- that no line address ever matches two buffer entries.

Where a line lives, swap correctness, least-recently-used eviction and write-no-allocate can only be shown by the bench's scenarios. The bench infers them from response latency, from refill requests and from the returned data, which it compares with its own placement model over directed conflicts and a long sweep of conflicting addresses.

// File: rtl/dmvc_cache.sv
module dmvc_cache #(
  parameter int ADDR_W = 10,
  parameter int WORD_W = 32,
  parameter int WPL    = 4,
  parameter int SETS   = 8,
  parameter int VB_N   = 4
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          req_valid,
  output logic                          req_ready,
  input  logic                          req_we,
  input  logic [ADDR_W-1:0]             req_addr,
  input  logic [WORD_W-1:0]             req_wdata,
  output logic                          rsp_valid,
  output logic [WORD_W-1:0]             rsp_rdata,
  output logic                          fill_req,
  output logic [ADDR_W-$clog2(WPL)-1:0] fill_addr,
  input  logic                          fill_valid,
  input  logic [WORD_W*WPL-1:0]         fill_data,
  output logic                          wt_valid,
  output logic [ADDR_W-1:0]             wt_addr,
  output logic [WORD_W-1:0]             wt_data
);
  localparam int OFF_W  = $clog2(WPL);
  localparam int IDX_W  = $clog2(SETS);
  localparam int LA_W   = ADDR_W - OFF_W;
  localparam int TAG_W  = LA_W - IDX_W;
  localparam int LINE_W = WORD_W * WPL;
  localparam int AGE_W  = $clog2(VB_N);

  typedef enum logic [1:0] {S_IDLE, S_SWAP, S_FILL} st_t;
  st_t st;

  logic [SETS-1:0]   dm_v;
  logic [TAG_W-1:0]  dm_tag  [SETS];
  logic [LINE_W-1:0] dm_data [SETS];
  logic [VB_N-1:0]   vb_v;
  logic [LA_W-1:0]   vb_la   [VB_N];
  logic [LINE_W-1:0] vb_data [VB_N];
  logic [AGE_W-1:0]  vb_age  [VB_N];
  logic [AGE_W-1:0]  age_touched [VB_N];

  logic [ADDR_W-1:0] q_addr;
  logic              q_we;
  logic [WORD_W-1:0] q_wdata;

  logic [ADDR_W-1:0] a;
  logic [LA_W-1:0]   la;
  logic [IDX_W-1:0]  idx;
  logic [TAG_W-1:0]  tag;
  logic [OFF_W-1:0]  off;
  logic              dm_hit, old_v;
  logic [LA_W-1:0]   old_la;
  logic [LINE_W-1:0] old_line;
  logic [VB_N-1:0]   vb_match;
  logic [AGE_W-1:0]  vb_way, ins_way, touch_way;

  function automatic logic [WORD_W-1:0] get_word(input logic [LINE_W-1:0] l, input logic [OFF_W-1:0] o);
    return l[o*WORD_W +: WORD_W];
  endfunction

  function automatic logic [LINE_W-1:0] put_word(input logic [LINE_W-1:0] l, input logic [OFF_W-1:0] o,
                                                 input logic [WORD_W-1:0] w);
    logic [LINE_W-1:0] r;
    r = l;
    r[o*WORD_W +: WORD_W] = w;
    return r;
  endfunction

  assign a        = (st == S_IDLE) ? req_addr : q_addr;
  assign la       = a[ADDR_W-1:OFF_W];
  assign idx      = la[IDX_W-1:0];
  assign tag      = la[LA_W-1:IDX_W];
  assign off      = a[OFF_W-1:0];
  assign old_v    = dm_v[idx];
  assign old_la   = {dm_tag[idx], idx};
  assign old_line = dm_data[idx];
  assign dm_hit   = old_v && (dm_tag[idx] == tag);

  assign req_ready = (st == S_IDLE);
  assign fill_req  = (st == S_FILL);
  assign fill_addr = q_addr[ADDR_W-1:OFF_W];

  for (genvar g = 0; g < VB_N; g++) begin : g_vb
    assign vb_match[g] = vb_v[g] && (vb_la[g] == la);
    assign age_touched[g] = (touch_way == AGE_W'(g)) ? '0 :
                            (vb_age[g] < vb_age[touch_way]) ? vb_age[g] + 1'b1 : vb_age[g];
  end

  always_comb begin
    vb_way = '0;
    for (int i = 0; i < VB_N; i++)
      if (vb_match[i]) vb_way = AGE_W'(i);
  end

  always_comb begin
    logic have_free;
    have_free = 1'b0;
    ins_way   = '0;
    for (int i = VB_N - 1; i >= 0; i--)
      if (!vb_v[i]) begin
        ins_way   = AGE_W'(i);
        have_free = 1'b1;
      end
    if (!have_free)
      for (int i = 0; i < VB_N; i++)
        if (vb_age[i] == AGE_W'(VB_N - 1)) ins_way = AGE_W'(i);
  end

  assign touch_way = (st == S_SWAP) ? vb_way : ins_way;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      dm_v      <= '0;
      vb_v      <= '0;
      for (int i = 0; i < VB_N; i++) vb_age[i] <= AGE_W'(i);
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
      wt_valid  <= 1'b0;
      wt_addr   <= '0;
      wt_data   <= '0;
      q_addr    <= '0;
      q_we      <= 1'b0;
      q_wdata   <= '0;
    end else begin
      rsp_valid <= 1'b0;
      wt_valid  <= 1'b0;
      case (st)
        S_IDLE: if (req_valid) begin
          q_addr  <= req_addr;
          q_we    <= req_we;
          q_wdata <= req_wdata;
          if (req_we) begin
            wt_valid <= 1'b1;
            wt_addr  <= req_addr;
            wt_data  <= req_wdata;
          end
          if (dm_hit) begin
            rsp_valid <= 1'b1;
            rsp_rdata <= get_word(old_line, off);
            if (req_we) dm_data[idx] <= put_word(old_line, off, req_wdata);
          end else if (|vb_match) begin
            st <= S_SWAP;
          end else if (req_we) begin
            rsp_valid <= 1'b1;
            rsp_rdata <= '0;
          end else begin
            st <= S_FILL;
          end
        end
        S_SWAP: begin
          dm_v[idx]       <= 1'b1;
          dm_tag[idx]     <= tag;
          dm_data[idx]    <= q_we ? put_word(vb_data[vb_way], off, q_wdata) : vb_data[vb_way];
          vb_v[vb_way]    <= old_v;
          vb_la[vb_way]   <= old_la;
          vb_data[vb_way] <= old_line;
          for (int i = 0; i < VB_N; i++) vb_age[i] <= age_touched[i];
          rsp_valid <= 1'b1;
          rsp_rdata <= get_word(vb_data[vb_way], off);
          st        <= S_IDLE;
        end
        S_FILL: if (fill_valid) begin
          if (old_v) begin
            vb_v[ins_way]    <= 1'b1;
            vb_la[ins_way]   <= old_la;
            vb_data[ins_way] <= old_line;
            for (int i = 0; i < VB_N; i++) vb_age[i] <= age_touched[i];
          end
          dm_v[idx]    <= 1'b1;
          dm_tag[idx]  <= tag;
          dm_data[idx] <= fill_data;
          rsp_valid    <= 1'b1;
          rsp_rdata    <= get_word(fill_data, off);
          st           <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/dmvc_cache_chk.sv
module dmvc_cache_chk #(
  parameter int ADDR_W = 10,
  parameter int WORD_W = 32,
  parameter int WPL    = 4,
  parameter int VB_N   = 4
) (
  input logic                          clk,
  input logic                          rst_n,
  input logic                          req_valid,
  input logic                          req_ready,
  input logic                          req_we,
  input logic [ADDR_W-1:0]             req_addr,
  input logic [WORD_W-1:0]             req_wdata,
  input logic                          rsp_valid,
  input logic                          fill_req,
  input logic [ADDR_W-$clog2(WPL)-1:0] fill_addr,
  input logic                          fill_valid,
  input logic                          wt_valid,
  input logic [ADDR_W-1:0]             wt_addr,
  input logic [WORD_W-1:0]             wt_data,
  input logic [VB_N-1:0]               vb_match
);
  localparam int OFF_W = $clog2(WPL);

  a_r10_busy_not_ready: assert property (@(posedge clk) disable iff (!rst_n)
    fill_req |-> !req_ready);

  a_r5_fill_held: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_req && !fill_valid) |=> (fill_req && $stable(fill_addr)));

  a_r5_fill_line_addr: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fill_req) |-> (fill_addr == $past(req_addr[ADDR_W-1:OFF_W])));

  a_r9_wt_from_store: assert property (@(posedge clk) disable iff (!rst_n)
    wt_valid |-> $past(req_valid && req_ready && req_we));

  a_r9_wt_payload: assert property (@(posedge clk) disable iff (!rst_n)
    wt_valid |-> (wt_addr == $past(req_addr) && wt_data == $past(req_wdata)));

  a_r2_rsp_has_cause: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> ($past(req_valid && req_ready) || $past(fill_req && fill_valid) ||
                   $past(!req_ready && !fill_req)));

  a_r11_unique_match: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(vb_match));
endmodule

bind dmvc_cache dmvc_cache_chk #(.ADDR_W(ADDR_W), .WORD_W(WORD_W), .WPL(WPL), .VB_N(VB_N)) chk_i (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready), .req_we(req_we),
  .req_addr(req_addr), .req_wdata(req_wdata), .rsp_valid(rsp_valid), .fill_req(fill_req),
  .fill_addr(fill_addr), .fill_valid(fill_valid), .wt_valid(wt_valid), .wt_addr(wt_addr),
  .wt_data(wt_data), .vb_match(vb_match)
);

// File: tb/dmvc_cache_tb_top.sv
`timescale 1ns/1ps
module dmvc_cache_tb_top;
  localparam int ADDR_W = 10, WORD_W = 32, WPL = 4, SETS = 8, VB_N = 4;
  localparam int OFF_W = 2, LA_W = ADDR_W - OFF_W, LINE_W = WORD_W * WPL, NWORDS = 1 << ADDR_W;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_we = 1'b0, fill_valid = 1'b0;
  logic [ADDR_W-1:0] req_addr = '0;
  logic [WORD_W-1:0] req_wdata = '0;
  logic [LINE_W-1:0] fill_data = '0;
  logic req_ready, rsp_valid, fill_req, wt_valid;
  logic [WORD_W-1:0] rsp_rdata, wt_data;
  logic [LA_W-1:0] fill_addr;
  logic [ADDR_W-1:0] wt_addr;

  always #2.5 clk = ~clk;

  dmvc_cache #(.ADDR_W(ADDR_W), .WORD_W(WORD_W), .WPL(WPL), .SETS(SETS), .VB_N(VB_N)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready), .req_we(req_we),
    .req_addr(req_addr), .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .fill_req(fill_req), .fill_addr(fill_addr), .fill_valid(fill_valid), .fill_data(fill_data),
    .wt_valid(wt_valid), .wt_addr(wt_addr), .wt_data(wt_data));

  int checks = 0, failures = 0, now = 0;
  bit done = 0;
  logic [WORD_W-1:0] mem [NWORDS];
  bit dm_mv [SETS];
  int dm_mla [SETS];
  bit vb_mv [VB_N];
  int vb_mla [VB_N];
  int vb_mts [VB_N];

  task automatic chk(input bit ok, input string req, input string what, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [LINE_W-1:0] mk_line(input int la);
    logic [LINE_W-1:0] l;
    for (int w = 0; w < WPL; w++) l[w*WORD_W +: WORD_W] = mem[la*WPL + w];
    return l;
  endfunction

  function automatic int predict(input int la, input bit we);
    int idx, hit, slot, best;
    idx = la % SETS;
    now++;
    if (dm_mv[idx] && dm_mla[idx] == la) return 0;
    hit = -1;
    for (int i = 0; i < VB_N; i++) if (vb_mv[i] && vb_mla[i] == la) hit = i;
    if (hit >= 0) begin
      vb_mv[hit] = dm_mv[idx]; vb_mla[hit] = dm_mla[idx]; vb_mts[hit] = now;
      dm_mv[idx] = 1; dm_mla[idx] = la;
      return 1;
    end
    if (we) return 3;
    if (dm_mv[idx]) begin
      slot = -1;
      for (int i = VB_N - 1; i >= 0; i--) if (!vb_mv[i]) slot = i;
      if (slot < 0) begin
        best = 0;
        for (int i = 1; i < VB_N; i++) if (vb_mts[i] < vb_mts[best]) best = i;
        slot = best;
      end
      vb_mv[slot] = 1; vb_mla[slot] = dm_mla[idx]; vb_mts[slot] = now;
    end
    dm_mv[idx] = 1; dm_mla[idx] = la;
    return 2;
  endfunction

  task automatic access(input int addr, input bit we, input logic [WORD_W-1:0] wd, input string req);
    int la, cls, lat, fw, act_cls, exp_cls;
    bit sawf, busy_ok, wt_ok;
    logic [LA_W-1:0] fa;
    logic [WORD_W-1:0] exp_d;
    string lbl;
    la = addr >> OFF_W;
    cls = predict(la, we);
    exp_d = mem[addr];
    lbl = (req.len() > 0) ? req : (cls == 0 ? "R2" : cls == 1 ? "R3" : cls == 2 ? "R5" : "R9");
    @(negedge clk);
    req_valid = 1'b1; req_we = we; req_addr = ADDR_W'(addr); req_wdata = wd;
    @(negedge clk);
    req_valid = 1'b0;
    if (we) mem[addr] = wd;
    lat = 1; fw = 0; sawf = 0; fa = '0;
    wt_ok = (wt_valid == we) && (!we || (wt_addr == ADDR_W'(addr) && wt_data == wd));
    busy_ok = rsp_valid || !req_ready;
    while (!rsp_valid && lat < 40) begin
      if (fill_req) begin
        if (!sawf) begin sawf = 1; fa = fill_addr; end
        fw++;
        if (fw == 3) begin fill_valid = 1'b1; fill_data = mk_line(la); end
      end
      @(negedge clk);
      fill_valid = 1'b0;
      lat++;
    end
    act_cls = sawf ? 2 : (lat == 1 ? 0 : (lat == 2 ? 1 : 9));
    exp_cls = (cls == 3) ? 0 : cls;
    chk(act_cls == exp_cls, lbl, "class", act_cls, exp_cls);
    if (!we) chk(rsp_valid && rsp_rdata == exp_d, lbl, "rdata", rsp_rdata, exp_d);
    chk(wt_ok, "R9", "wt", {wt_valid, wt_addr}, {we, ADDR_W'(addr)});
    if (cls == 1 || cls == 2) chk(busy_ok, "R10", "ready", req_ready, 0);
    if (sawf) chk(fa == LA_W'(la), "R5", "fill_addr", fa, la);
  endtask

  function automatic int A(input int t, input int off);
    return ((t * SETS) * WPL) + off;
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < NWORDS; i++) mem[i] = i * 32'h9E3779B1 + 32'h1234;
    for (int i = 0; i < SETS; i++) begin dm_mv[i] = 0; dm_mla[i] = 0; end
    for (int i = 0; i < VB_N; i++) begin vb_mv[i] = 0; vb_mla[i] = 0; vb_mts[i] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready && !rsp_valid && !fill_req && !wt_valid, "R1", "reset outputs",
        {req_ready, rsp_valid, fill_req, wt_valid}, 4'b1000);

    access(A(0, 1), 0, '0, "R1");
    access(A(0, 2), 0, '0, "R2");
    access(A(1, 0), 0, '0, "R6");
    access(A(0, 3), 0, '0, "R3");
    access(A(0, 0), 0, '0, "R4");
    access(A(1, 1), 0, '0, "R4");
    access(A(2, 0), 0, '0, "R6");
    access(A(3, 1), 0, '0, "R6");
    access(A(4, 2), 0, '0, "R6");
    access(A(0, 3), 0, '0, "R11");
    access(A(2, 2), 0, '0, "R8");
    access(A(5, 0), 0, '0, "R7");
    access(A(1, 3), 0, '0, "R7");
    access(A(4, 1), 0, '0, "R8");
    access(A(4, 1), 1, 32'hCAFE0001, "R9");
    access(A(4, 1), 0, '0, "R9");
    access(A(6, 2), 1, 32'hCAFE0002, "R9");
    access(A(6, 2), 0, '0, "R9");
    access(A(5, 3), 1, 32'hCAFE0003, "R9");
    access(A(5, 3), 0, '0, "R9");

    for (int i = 0; i < 600; i++) begin
      int t, ix, addr;
      t  = (i * 5 + i / 7) % 6;
      ix = (i * 3 + i / 11) % 4;
      addr = ((t * SETS + ix) * WPL) + (i % WPL);
      access(addr, (i % 6) == 4, i * 32'h01010101 ^ 32'hA5A50000, "");
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule